// File: doc/BRIEF.md
# Commandable Up/Down Timer Channel

This block is one timer/counter channel. It advances on a prescaled count tick, either upward or downward. It holds an active period and an active compare value. Each of these has a buffer register in front of it, which software writes freely. A small state machine tracks whether the channel is halted or counting. The machine also carries out the software commands.

Software steers the channel through an 8-bit control byte that sits behind two bus addresses. A write to the set address raises every bit written as 1. A write to the clear address lowers every bit written as 1. Both addresses read back the same byte, so single bits change without a read-modify-write. The top three bits hold a pending command, which runs on the next tick and then clears itself. The remaining bits select one-shot mode, lock the buffer copy, and set the count direction. A plain register port gives access to the buffers, the active values and a count snapshot.

State machine: `ST_IDLE` (halted, count frozen) and `ST_RUN` (counting on each tick). The transitions are:
- `ST_IDLE -> ST_RUN` on a retrigger.
- `ST_RUN -> ST_RUN` on a retrigger (restart).
- `ST_RUN -> ST_IDLE` on a stop.
- `ST_RUN -> ST_IDLE` on a one-shot wrap.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control byte reads 0x00, the count is 0, the channel is halted and the active period reads the parameter `PER_INIT` (default 0xFFFF).
- R2: A write to address 1 (set view) raises control bits 2:0 wherever the written data has a 1 and leaves the others unchanged; a write of 0 changes nothing.
- R3: A write to address 0 (clear view) lowers control bits 2:0 wherever the written data has a 1; both address 0 and address 1 read back the same control byte in data bits 7:0.
- R4: A nonzero value written to data bits 7:5 at address 1 becomes the pending command (1 retrigger, 2 stop, 3 force update, 4 count snapshot); writing 0 there leaves any pending command unchanged.
- R5: A pending command executes on the next cycle with `tick` high, and from the following cycle bits 7:5 of the control byte read 0.
- R6: The count and run state change only in cycles with `tick` high; while running, control bit 0 = 0 counts up and wraps from the active period to 0, and bit 0 = 1 counts down and wraps from 0 to the active period.
- R7: Retrigger loads 0 when counting up and the active period when counting down, and enters `ST_RUN`.
- R8: A snapshot command (4) copies the count as it stood before that tick into the read register at address 4; counting continues normally on that tick.
- R9: A stop command (2) enters `ST_IDLE` and leaves the count unchanged on that tick and afterwards.
- R10: With control bit 2 (one-shot) set, the wrap still occurs but the channel enters `ST_IDLE` on that wrap; with it clear, the channel keeps counting.
- R11: At a wrap the buffers (period at address 2, compare at address 3) are copied to the active registers (read at 5 and 6) unless control bit 1 (lock) is set; the force-update command (3) copies them even when locked.
- R12: While input `cap_mode` is high, the lock bit is ignored and a wrap copies the buffers.
- R13: Command values 5, 6 and 7 perform no action, but are cleared on the next tick like any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable, one cycle per count step |
| cap_mode | input | 1 | Input capture mode in use; forces the buffer copy at a wrap |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 clear view, 1 set view, 2 period buffer, 3 compare buffer, 4 snapshot, 5 active period, 6 active compare) |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| count_o | output | CNT_W | Live count value |
| running_o | output | 1 | High while the state machine is in `ST_RUN` |
| match_o | output | 1 | High while running and the count equals the active compare |

## Verification
The assertions assume that a write to the set view carrying a new command does not land in the same cycle as a tick that executes the previous command. They also assume that `tick` is a clean single-cycle strobe, sampled synchronously with the bus. The bench follows both assumptions in the same way. Every register write completes between two ticks, and each tick is driven for exactly one cycle with no bus activity in that cycle. A command therefore always becomes pending before the tick that runs it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_RETRIG = 3'd1,
        CMD_STOP   = 3'd2,
        CMD_UPDATE = 3'd3,
        CMD_SNAP   = 3'd4
    } tmr_cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    // control byte bit positions
    localparam int unsigned BIT_DIR   = 0;
    localparam int unsigned BIT_LOCK  = 1;
    localparam int unsigned BIT_ONE   = 2;
    localparam int unsigned CMD_LSB   = 5;
    localparam int unsigned CMD_MSB   = 7;

    // register addresses
    localparam int unsigned A_CLR  = 0;
    localparam int unsigned A_SET  = 1;
    localparam int unsigned A_PERB = 2;
    localparam int unsigned A_CCB  = 3;
    localparam int unsigned A_SNAP = 4;
    localparam int unsigned A_PER  = 5;
    localparam int unsigned A_CC   = 6;

endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_set,
    input  logic       wr_clr,
    input  logic [7:0] wdata,
    input  logic       cmd_done,
    output logic [7:0] ctrl
);
    logic [2:0] mode_q;
    logic [2:0] cmd_q;
    logic       new_cmd;

    assign new_cmd = wr_set && (wdata[CMD_MSB:CMD_LSB] != 3'd0);

    // mode bits: set view raises, clear view lowers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 3'b000;
        end else if (wr_set) begin
            mode_q <= mode_q | wdata[2:0];
        end else if (wr_clr) begin
            mode_q <= mode_q & ~wdata[2:0];
        end
    end

    // pending command: a fresh write wins over completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= 3'd0;
        end else if (new_cmd) begin
            cmd_q <= wdata[CMD_MSB:CMD_LSB];
        end else if (cmd_done) begin
            cmd_q <= 3'd0;
        end
    end

    assign ctrl = {cmd_q, 2'b00, mode_q};

endmodule

// File: rtl/tmr_buf.sv
module tmr_buf #(
    parameter int unsigned CNT_W    = 16,
    parameter logic [CNT_W-1:0] PER_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_per,
    input  logic             wr_cc,
    input  logic [CNT_W-1:0] wdata,
    input  logic             copy,
    output logic [CNT_W-1:0] per_buf,
    output logic [CNT_W-1:0] cc_buf,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cc_act
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_buf <= PER_INIT;
            cc_buf  <= '0;
        end else begin
            if (wr_per) per_buf <= wdata;
            if (wr_cc)  cc_buf  <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_act <= PER_INIT;
            cc_act  <= '0;
        end else if (copy) begin
            per_act <= per_buf;
            cc_act  <= cc_buf;
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_cmd_e         cmd,
    input  logic             dir_down,
    input  logic             one_shot,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] snap,
    output logic             running,
    output logic             wrap,
    output logic             cmd_done,
    output logic             force_upd
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] snap_q, snap_d;
    logic             at_end;
    logic [CNT_W-1:0] start_val;

    assign at_end    = dir_down ? (cnt_q == '0) : (cnt_q == per);
    assign start_val = dir_down ? per : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            snap_q  <= snap_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd == CMD_RETRIG) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (cmd == CMD_STOP)
                        state_d = ST_IDLE;
                    else if (cmd != CMD_RETRIG && at_end && one_shot)
                        state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // datapath outputs
    always_comb begin
        cnt_d  = cnt_q;
        snap_d = snap_q;
        wrap   = 1'b0;
        if (tick) begin
            if (cmd == CMD_SNAP) snap_d = cnt_q;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd == CMD_RETRIG) cnt_d = start_val;
                end
                ST_RUN: begin
                    if (cmd == CMD_RETRIG) begin
                        cnt_d = start_val;
                    end else if (cmd != CMD_STOP) begin
                        if (at_end) begin
                            cnt_d = start_val;
                            wrap  = 1'b1;
                        end else if (dir_down) begin
                            cnt_d = cnt_q - 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: cnt_d = cnt_q;
            endcase
        end
    end

    assign cmd_done  = tick && (cmd != CMD_NONE);
    assign force_upd = tick && (cmd == CMD_UPDATE);
    assign count     = cnt_q;
    assign snap      = snap_q;
    assign running   = (state_q == ST_RUN);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned      CNT_W    = 16,
    parameter int unsigned      ADDR_W   = 3,
    parameter logic [CNT_W-1:0] PER_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cap_mode,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic              running_o,
    output logic              match_o
);
    logic [7:0]       ctrl_q;
    logic             wr_set, wr_clr, wr_per, wr_cc;
    logic             cmd_done, force_upd, wrap, copy;
    logic [CNT_W-1:0] per_buf, cc_buf, per_act, cc_act, snap;
    tmr_cmd_e         cmd;

    assign wr_set = bus_wr && (bus_addr == ADDR_W'(A_SET));
    assign wr_clr = bus_wr && (bus_addr == ADDR_W'(A_CLR));
    assign wr_per = bus_wr && (bus_addr == ADDR_W'(A_PERB));
    assign wr_cc  = bus_wr && (bus_addr == ADDR_W'(A_CCB));

    tmr_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_set   (wr_set),
        .wr_clr   (wr_clr),
        .wdata    (bus_wdata[7:0]),
        .cmd_done (cmd_done),
        .ctrl     (ctrl_q)
    );

    assign cmd = tmr_cmd_e'(ctrl_q[CMD_MSB:CMD_LSB]);

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd       (cmd),
        .dir_down  (ctrl_q[BIT_DIR]),
        .one_shot  (ctrl_q[BIT_ONE]),
        .per       (per_act),
        .count     (count_o),
        .snap      (snap),
        .running   (running_o),
        .wrap      (wrap),
        .cmd_done  (cmd_done),
        .force_upd (force_upd)
    );

    assign copy = force_upd || (wrap && (!ctrl_q[BIT_LOCK] || cap_mode));

    tmr_buf #(.CNT_W(CNT_W), .PER_INIT(PER_INIT)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_per  (wr_per),
        .wr_cc   (wr_cc),
        .wdata   (bus_wdata),
        .copy    (copy),
        .per_buf (per_buf),
        .cc_buf  (cc_buf),
        .per_act (per_act),
        .cc_act  (cc_act)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(A_CLR), ADDR_W'(A_SET): bus_rdata = CNT_W'(ctrl_q);
            ADDR_W'(A_PERB): bus_rdata = per_buf;
            ADDR_W'(A_CCB):  bus_rdata = cc_buf;
            ADDR_W'(A_SNAP): bus_rdata = snap;
            ADDR_W'(A_PER):  bus_rdata = per_act;
            ADDR_W'(A_CC):   bus_rdata = cc_act;
            default:         bus_rdata = '0;
        endcase
    end

    assign match_o = running_o && (count_o == cc_act);

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              cap_mode,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [7:0]        ctrl,
    input logic [CNT_W-1:0]  count,
    input logic              running,
    input logic [CNT_W-1:0]  per_act
);
    logic set_w, clr_w, cmd_w;
    assign set_w = bus_wr && (bus_addr == ADDR_W'(1));
    assign clr_w = bus_wr && (bus_addr == ADDR_W'(0));
    assign cmd_w = set_w && (bus_wdata[7:5] != 3'd0);

    a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |=> ((ctrl[2:0] & $past(bus_wdata[2:0])) == $past(bus_wdata[2:0])));

    a_r3_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> ((ctrl[2:0] & $past(bus_wdata[2:0])) == 3'b000));

    a_r5_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl[7:5] != 3'd0 && !cmd_w) |=> (ctrl[7:5] == 3'd0));

    a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(count) && $stable(running)));

    a_r9_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl[7:5] == 3'd2) |=> (!running && $stable(count)));

    a_r11_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || (ctrl[7:5] != 3'd3 && ctrl[1] && !cap_mode)) |=> $stable(per_act));

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cap_mode  (cap_mode),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl      (ctrl_q),
    .count     (count_o),
    .running   (running_o),
    .per_act   (per_act)
);

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
    localparam int CW = 16;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          cap_mode = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic [CW-1:0] count_o;
    logic          running_o;
    logic          match_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr_channel #(.CNT_W(CW), .ADDR_W(AW), .PER_INIT(16'hFFFF)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_mode(cap_mode),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .count_o(count_o), .running_o(running_o),
        .match_o(match_o)
    );

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [CW-1:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [CW-1:0] data);
        bus_addr = AW'(addr);
        #1 data = bus_rdata;
    endtask

    task automatic step();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [CW-1:0] d;
        rd(1, d); check("R1 ctrl", d, 16'h0000);
        check("R1 count", count_o, 16'd0);
        check("R1 running", CW'(running_o), 16'd0);
        rd(5, d); check("R1 period", d, 16'hFFFF);
    endtask

    task automatic t_set_clear();
        logic [CW-1:0] d;
        wr(1, 16'h0007); rd(1, d); check("R2 set", d, 16'h0007);
        wr(1, 16'h0000); rd(1, d); check("R2 set zero", d, 16'h0007);
        wr(0, 16'h0002); rd(0, d); check("R3 clr view", d, 16'h0005);
        rd(1, d); check("R3 same byte", d, 16'h0005);
        wr(0, 16'h0007); rd(1, d); check("R3 clr all", d, 16'h0000);
    endtask

    task automatic t_force_update();
        logic [CW-1:0] d;
        wr(2, 16'd5);
        wr(1, 16'h0060); rd(1, d); check("R4 pending", d, 16'h0060);
        wr(1, 16'h0000); rd(1, d); check("R4 zero keeps", d, 16'h0060);
        step(); rd(1, d); check("R5 cleared", d, 16'h0000);
        rd(5, d); check("R11 forced copy", d, 16'd5);
    endtask

    task automatic t_up_count();
        wr(1, 16'h0020); step();
        check("R7 run", CW'(running_o), 16'd1);
        check("R7 start up", count_o, 16'd0);
        repeat (3) @(negedge clk);
        check("R6 no tick hold", count_o, 16'd0);
        for (int i = 1; i <= 5; i++) begin
            step(); check("R6 up", count_o, CW'(i));
        end
        step(); check("R6 up wrap", count_o, 16'd0);
        check("R10 keeps running", CW'(running_o), 16'd1);
    endtask

    task automatic t_snapshot();
        logic [CW-1:0] d;
        repeat (3) step();
        wr(1, 16'h0080); step();
        rd(4, d); check("R8 snapshot", d, 16'd3);
        check("R8 continues", count_o, 16'd4);
    endtask

    task automatic t_stop();
        wr(1, 16'h0040); step();
        check("R9 halted", CW'(running_o), 16'd0);
        check("R9 count kept", count_o, 16'd4);
        repeat (2) step();
        check("R9 frozen", count_o, 16'd4);
    endtask

    task automatic t_down();
        wr(1, 16'h0001); wr(1, 16'h0020); step();
        check("R7 start down", count_o, 16'd5);
        for (int i = 4; i >= 0; i--) begin
            step(); check("R6 down", count_o, CW'(i));
        end
        step(); check("R6 down wrap", count_o, 16'd5);
    endtask

    task automatic t_one_shot();
        wr(0, 16'h0001); wr(1, 16'h0004); wr(1, 16'h0020); step();
        repeat (5) step();
        check("R10 at period", count_o, 16'd5);
        step();
        check("R10 wrapped", count_o, 16'd0);
        check("R10 halted", CW'(running_o), 16'd0);
        step(); check("R10 stays", count_o, 16'd0);
    endtask

    task automatic t_lock();
        logic [CW-1:0] d;
        wr(0, 16'h0004); wr(1, 16'h0002); wr(2, 16'd3);
        wr(1, 16'h0020); step();
        repeat (6) step();
        check("R11 wrap locked", count_o, 16'd0);
        rd(5, d); check("R11 lock blocks", d, 16'd5);
        wr(1, 16'h0060); step();
        rd(5, d); check("R11 force over lock", d, 16'd3);
        check("R11 count", count_o, 16'd1);
        wr(2, 16'd2); cap_mode = 1'b1;
        repeat (3) step();
        check("R12 wrap", count_o, 16'd0);
        rd(5, d); check("R12 lock ignored", d, 16'd2);
        cap_mode = 1'b0;
    endtask

    task automatic t_bad_cmd();
        logic [CW-1:0] d;
        wr(1, 16'h00E0); rd(1, d); check("R13 pending", d, 16'h00E2);
        step(); rd(1, d); check("R13 cleared", d, 16'h0002);
        check("R13 still running", CW'(running_o), 16'd1);
        check("R13 counts on", count_o, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_force_update();
        t_up_count();
        t_snapshot();
        t_stop();
        t_down();
        t_one_shot();
        t_lock();
        t_bad_cmd();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule